// File: doc/BRIEF.md
# ADC Result Streaming Sequencer

This block connects the byte layer of a two-wire serial slave to a single-channel-at-a-time converter interface. The byte layer reports three things to it: the register pointer the master wrote, the start of a read transfer, and each byte request and master acknowledge. When a read begins while the pointer holds one of the measurement channel addresses, the sequencer starts one conversion on that channel. It then answers the next two byte requests with the result, padded to a 16-bit word.

While the master keeps acknowledging the second byte of each pair, the sequencer starts another conversion on the same channel and serves the fresh result. No new address phase is needed. A byte pair is never mixed across conversions, because each result is captured when the converter signals completion. A not-acknowledge, or a STOP or repeated START, ends the stream. If that bus event lands while a conversion is running, the sequencer lets the conversion finish and then goes idle without sending anything.

Top module: `adc_stream_seq`

## Requirements
- R1: After reset the sequencer is idle: `adc_start` and `byte_vld` are low, and no conversion starts until a read is requested.
- R2: When `rd_start` pulses and the last written pointer lies in `CH_BASE` .. `CH_BASE+NUM_CH-1`, exactly one conversion is launched. The launch is a one-cycle `adc_start` pulse, and `adc_chan` equals the pointer minus `CH_BASE`.
- R3: A read on a pointer outside that window launches no conversion and produces no byte, even when bytes are requested.
- R4: Each result is sent as two bytes, upper byte first. The first byte is bits 11..4 of the 12-bit sample. The second byte carries bits 3..0 of the sample in its bits 7..4 and zeros in its bits 3..0. Each byte is marked by a one-cycle `byte_vld` pulse.
- R5: An acknowledge (`ack_vld` with `ack_bit`=1) after the first byte only releases the second byte. It starts no conversion.
- R6: An acknowledge after the second byte launches a new conversion on the same channel. The next two bytes carry that new result.
- R7: A not-acknowledge (`ack_bit`=0) after either byte ends the stream. No further conversion or byte follows until a new read.
- R8: A byte request that arrives before the conversion completes is remembered. The upper byte is delivered only after `adc_done`, and it is delivered even when the request and `adc_done` fall in the same cycle.
- R9: The sample is captured in the cycle `adc_done` is high. Later changes of `adc_data` do not alter the bytes served.
- R10: A `bus_stop` during a conversion cancels the stream. This holds even when it arrives in the same cycle as `adc_done`. No byte is sent for that conversion, and a later read on a channel works normally.
- R11: A `bus_stop` while a byte pair is being transferred ends the stream. No further byte and no new conversion follow.
- R12: A conversion is launched only in a cycle after `adc_busy` was low. While `adc_busy` stays high the launch waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr_vld | input | 1 | Pulse: a register pointer byte was written |
| wr_addr | input | ADDR_W | Pointer value written |
| rd_start | input | 1 | Pulse: a read transfer begins |
| byte_req | input | 1 | Pulse: the byte layer needs the next byte to send |
| byte_vld | output | 1 | Pulse: `byte_data` holds the requested byte |
| byte_data | output | 8 | Byte to transmit |
| ack_vld | input | 1 | Pulse: the master acknowledge bit for the last byte is known |
| ack_bit | input | 1 | 1 = acknowledge, 0 = not-acknowledge |
| bus_stop | input | 1 | Pulse: STOP or repeated START seen on the bus |
| adc_start | output | 1 | One-cycle conversion launch |
| adc_chan | output | CH_W | Channel for the conversion |
| adc_busy | input | 1 | Converter cannot accept a launch |
| adc_done | input | 1 | Pulse: conversion complete, `adc_data` valid |
| adc_data | input | DATA_W | Conversion result |

## Verification
Two events can share one clock cycle: the completion of a conversion and a bus event that has to be reconciled with it. The bench aligns a byte request exactly with the rising `adc_done` and expects the upper byte of that new sample to follow. It also aligns a `bus_stop` with the rising `adc_done` and expects silence. A scoreboard compares every emitted byte against values derived from the converter model's sample sequence. The model corrupts `adc_data` right after each completion, so any failure to capture the sample shows up as a byte mismatch.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_CONV,
        ST_HI,
        ST_ACK1,
        ST_LO,
        ST_ACK2
    } seq_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } byte_pair_t;

    function automatic byte_pair_t split_word(input logic [WORD_W-1:0] w);
        byte_pair_t p;
        p.hi = w[WORD_W-1:BYTE_W];
        p.lo = w[BYTE_W-1:0];
        return p;
    endfunction

    function automatic logic in_window(input int unsigned val,
                                       input int unsigned base,
                                       input int unsigned count);
        return (val >= base) && (val < base + count);
    endfunction

endpackage

// File: rtl/adcs_ptr_dec.sv
module adcs_ptr_dec #(
    parameter int ADDR_W  = 8,
    parameter int CH_BASE = 'hD0,
    parameter int NUM_CH  = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              is_chan,
    output logic [CH_W-1:0]   chan_idx
);
    import adcs_pkg::*;

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] offs;

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= '0;
        else if (wr_vld) ptr_q <= wr_addr;
    end

    assign offs     = ptr_q - ADDR_W'(CH_BASE);
    assign is_chan  = in_window(int'(unsigned'(ptr_q)), CH_BASE, NUM_CH);
    assign chan_idx = offs[CH_W-1:0];

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_vld |=> $stable(ptr_q)); // R3

endmodule

// File: rtl/adcs_result.sv
module adcs_result #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] sample,
    input  logic              sel_lo,
    output logic [7:0]        byte_out
);
    import adcs_pkg::*;

    localparam int PAD_W = WORD_W - DATA_W;

    logic [DATA_W-1:0] samp_q;
    logic [WORD_W-1:0] word;
    byte_pair_t        pair;

    always_ff @(posedge clk) begin
        if (rst)         samp_q <= '0;
        else if (cap_en) samp_q <= sample;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {samp_q, {PAD_W{1'b0}}};
        end else begin : g_trunc
            assign word = samp_q[DATA_W-1 -: WORD_W];
        end
    endgenerate

    assign pair     = split_word(word);
    assign byte_out = sel_lo ? pair.lo : pair.hi;

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(samp_q)); // R9

endmodule

// File: rtl/adcs_ctrl.sv
module adcs_ctrl #(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_start,
    input  logic            ptr_is_chan,
    input  logic [CH_W-1:0] ptr_chan,
    input  logic            byte_req,
    input  logic            ack_vld,
    input  logic            ack_bit,
    input  logic            bus_stop,
    input  logic            adc_busy,
    input  logic            adc_done,
    output logic            adc_start,
    output logic [CH_W-1:0] adc_chan,
    output logic            cap_en,
    output logic            sel_lo,
    output logic            byte_vld
);
    import adcs_pkg::*;

    seq_state_e      st_q, st_d;
    logic            req_q, req_d;
    logic            cancel_q, cancel_d;
    logic            start_q, start_d;
    logic            vld_q, vld_d;
    logic            sel_q, sel_d;
    logic [CH_W-1:0] chan_q, chan_d;

    always_comb begin
        st_d     = st_q;
        req_d    = req_q | byte_req;
        cancel_d = cancel_q;
        start_d  = 1'b0;
        vld_d    = 1'b0;
        sel_d    = sel_q;
        chan_d   = chan_q;
        unique case (st_q)
            ST_IDLE: begin
                req_d    = 1'b0;
                cancel_d = 1'b0;
                if (rd_start && ptr_is_chan) begin
                    chan_d = ptr_chan;
                    st_d   = ST_ARM;
                end
            end
            ST_ARM: begin
                if (bus_stop) begin
                    st_d = ST_IDLE;
                end else if (!adc_busy) begin
                    start_d = 1'b1;
                    st_d    = ST_CONV;
                end
            end
            ST_CONV: begin
                if (bus_stop) cancel_d = 1'b1;
                if (adc_done) begin
                    st_d = (cancel_q || bus_stop) ? ST_IDLE : ST_HI;
                end
            end
            ST_HI: begin
                if (bus_stop) begin
                    st_d = ST_IDLE;
                end else if (req_q || byte_req) begin
                    vld_d = 1'b1;
                    sel_d = 1'b0;
                    req_d = 1'b0;
                    st_d  = ST_ACK1;
                end
            end
            ST_ACK1: begin
                if (bus_stop)     st_d = ST_IDLE;
                else if (ack_vld) st_d = ack_bit ? ST_LO : ST_IDLE;
            end
            ST_LO: begin
                if (bus_stop) begin
                    st_d = ST_IDLE;
                end else if (req_q || byte_req) begin
                    vld_d = 1'b1;
                    sel_d = 1'b1;
                    req_d = 1'b0;
                    st_d  = ST_ACK2;
                end
            end
            ST_ACK2: begin
                if (bus_stop)     st_d = ST_IDLE;
                else if (ack_vld) st_d = ack_bit ? ST_ARM : ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            req_q    <= 1'b0;
            cancel_q <= 1'b0;
            start_q  <= 1'b0;
            vld_q    <= 1'b0;
            sel_q    <= 1'b0;
            chan_q   <= '0;
        end else begin
            st_q     <= st_d;
            req_q    <= req_d;
            cancel_q <= cancel_d;
            start_q  <= start_d;
            vld_q    <= vld_d;
            sel_q    <= sel_d;
            chan_q   <= chan_d;
        end
    end

    assign adc_start = start_q;
    assign adc_chan  = chan_q;
    assign cap_en    = (st_q == ST_CONV) && adc_done;
    assign sel_lo    = sel_q;
    assign byte_vld  = vld_q;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q); // R2

    AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        start_q |-> !$past(adc_busy)); // R12

    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q); // R4

    AST_NO_BYTE_IN_CONV: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CONV) |-> !vld_q); // R8

    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |=> $stable(chan_q)); // R6

endmodule

// File: rtl/adc_stream_seq.sv
module adc_stream_seq #(
    parameter int ADDR_W  = 8,
    parameter int CH_BASE = 'hD0,
    parameter int NUM_CH  = 4,
    parameter int DATA_W  = 12,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rd_start,
    input  logic              byte_req,
    output logic              byte_vld,
    output logic [7:0]        byte_data,
    input  logic              ack_vld,
    input  logic              ack_bit,
    input  logic              bus_stop,
    output logic              adc_start,
    output logic [CH_W-1:0]   adc_chan,
    input  logic              adc_busy,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data
);

    logic            ptr_is_chan;
    logic [CH_W-1:0] ptr_chan;
    logic            cap_en;
    logic            sel_lo;

    adcs_ptr_dec #(
        .ADDR_W (ADDR_W),
        .CH_BASE(CH_BASE),
        .NUM_CH (NUM_CH)
    ) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .wr_vld  (wr_addr_vld),
        .wr_addr (wr_addr),
        .is_chan (ptr_is_chan),
        .chan_idx(ptr_chan)
    );

    adcs_ctrl #(
        .CH_W(CH_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rd_start   (rd_start),
        .ptr_is_chan(ptr_is_chan),
        .ptr_chan   (ptr_chan),
        .byte_req   (byte_req),
        .ack_vld    (ack_vld),
        .ack_bit    (ack_bit),
        .bus_stop   (bus_stop),
        .adc_busy   (adc_busy),
        .adc_done   (adc_done),
        .adc_start  (adc_start),
        .adc_chan   (adc_chan),
        .cap_en     (cap_en),
        .sel_lo     (sel_lo),
        .byte_vld   (byte_vld)
    );

    adcs_result #(
        .DATA_W(DATA_W)
    ) u_res (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .sample  (adc_data),
        .sel_lo  (sel_lo),
        .byte_out(byte_data)
    );

endmodule

// File: tb/adc_stream_seq_bench.sv
module adc_stream_seq_bench;

    localparam int ADDR_W  = 8;
    localparam int CH_BASE = 'hD0;
    localparam int NUM_CH  = 4;
    localparam int DATA_W  = 12;
    localparam int CH_W    = 2;
    localparam int LAT     = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_addr_vld = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              rd_start = 1'b0;
    logic              byte_req = 1'b0;
    logic              byte_vld;
    logic [7:0]        byte_data;
    logic              ack_vld = 1'b0;
    logic              ack_bit = 1'b0;
    logic              bus_stop = 1'b0;
    logic              adc_start;
    logic [CH_W-1:0]   adc_chan;
    logic              adc_busy;
    logic              adc_done = 1'b0;
    logic [DATA_W-1:0] adc_data = '0;
    logic              mdl_busy = 1'b0;
    logic              ext_busy = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int n_bytes  = 0;
    int n_starts = 0;
    int last_chan = -1;
    int conv_idx = 0;
    int pred_idx = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    assign adc_busy = mdl_busy | ext_busy;

    adc_stream_seq #(
        .ADDR_W (ADDR_W),
        .CH_BASE(CH_BASE),
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_adc_stream_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_addr_vld(wr_addr_vld),
        .wr_addr    (wr_addr),
        .rd_start   (rd_start),
        .byte_req   (byte_req),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .ack_vld    (ack_vld),
        .ack_bit    (ack_bit),
        .bus_stop   (bus_stop),
        .adc_start  (adc_start),
        .adc_chan   (adc_chan),
        .adc_busy   (adc_busy),
        .adc_done   (adc_done),
        .adc_data   (adc_data)
    );

    function automatic logic [11:0] sample_val(input int i);
        return 12'((i * 1117) + 291);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // converter model; data is scrambled right after each completion (R9)
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start) begin
                mdl_busy = 1'b1;
                repeat (LAT) @(negedge clk);
                adc_data = sample_val(conv_idx);
                conv_idx++;
                adc_done = 1'b1;
                @(negedge clk);
                adc_done = 1'b0;
                mdl_busy = 1'b0;
                adc_data = adc_data ^ 12'hFFF;
            end
        end
    end

    // monitor: scoreboard compare and launch counting
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start) begin
                n_starts++;
                last_chan = int'(adc_chan);
            end
            if (byte_vld) begin
                n_bytes++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected byte", int'(byte_data), 0);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(byte_data == e, t, int'(byte_data), int'(e));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_addr(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        wr_addr_vld = 1'b1;
        wr_addr = a;
        @(negedge clk);
        wr_addr_vld = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        byte_req = 1'b1;
        @(negedge clk);
        byte_req = 1'b0;
    endtask

    task automatic pulse_ack(input logic b);
        @(negedge clk);
        ack_vld = 1'b1;
        ack_bit = b;
        @(negedge clk);
        ack_vld = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
    endtask

    task automatic wait_bytes(input int t);
        while (n_bytes < t) @(posedge clk);
    endtask

    task automatic wait_starts(input int t);
        while (n_starts < t) @(posedge clk);
    endtask

    // R4: expected pair, upper byte = sample[11:4], lower = {sample[3:0], 0000}
    task automatic expect_pair(input string tag);
        logic [11:0] v;
        v = sample_val(pred_idx);
        pred_idx++;
        exp_q.push_back(v[11:4]);
        tag_q.push_back({tag, " hi byte"});
        exp_q.push_back({v[3:0], 4'h0});
        tag_q.push_back({tag, " lo byte"});
    endtask

    initial begin
        int b0;
        int s0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(2);
        // R1 reset state
        chk(byte_vld == 1'b0, "R1 byte_vld", int'(byte_vld), 0);
        chk(adc_start == 1'b0, "R1 adc_start", int'(adc_start), 0);
        chk(n_starts == 0, "R1 starts", n_starts, 0);

        // R3 pointer outside window: below and just above
        pulse_addr(8'h12);
        pulse_rd();
        pulse_req();
        idle(20);
        chk(n_starts == 0, "R3 low addr starts", n_starts, 0);
        pulse_addr(8'(CH_BASE + NUM_CH));
        pulse_rd();
        pulse_req();
        idle(20);
        chk(n_starts == 0, "R3 high addr starts", n_starts, 0);
        chk(n_bytes == 0, "R3 bytes", n_bytes, 0);

        // R2 / R8 / R5 / R6 / R7 streaming on channel 2
        pulse_addr(8'(CH_BASE + 2));
        expect_pair("R4 first");
        pulse_rd();
        pulse_req();
        idle(2);
        chk(n_bytes == 0, "R8 no byte before done", n_bytes, 0);
        wait_starts(1);
        idle(1);
        chk(last_chan == 2, "R2 channel", last_chan, 2);
        wait_bytes(1);
        idle(1);
        pulse_ack(1'b1);
        idle(10);
        chk(n_starts == 1, "R5 ack1 no launch", n_starts, 1);
        chk(n_bytes == 1, "R5 lo byte waits for request", n_bytes, 1);
        pulse_req();
        wait_bytes(2);
        idle(1);
        expect_pair("R6 second");
        pulse_ack(1'b1);
        wait_starts(2);
        idle(1);
        chk(last_chan == 2, "R6 same channel", last_chan, 2);
        // R8 request in the same cycle as done
        @(posedge adc_done);
        byte_req = 1'b1;
        @(negedge clk);
        byte_req = 1'b0;
        wait_bytes(3);
        idle(1);
        pulse_ack(1'b1);
        pulse_req();
        wait_bytes(4);
        idle(1);
        expect_pair("R6 third");
        pulse_ack(1'b1);
        pulse_req();
        wait_bytes(5);
        idle(1);
        pulse_ack(1'b1);
        pulse_req();
        wait_bytes(6);
        idle(1);
        pulse_ack(1'b0);
        pulse_stop();
        pulse_req();
        idle(30);
        chk(n_starts == 3, "R7 no launch after nack", n_starts, 3);
        chk(n_bytes == 6, "R7 no byte after nack", n_bytes, 6);

        // R10 stop during conversion
        s0 = n_starts;
        b0 = n_bytes;
        pred_idx++;
        pulse_rd();
        wait_starts(s0 + 1);
        pulse_stop();
        pulse_req();
        idle(30);
        chk(n_bytes == b0, "R10 cancelled no byte", n_bytes, b0);
        // R10 stop in the same cycle as done
        pred_idx++;
        pulse_rd();
        pulse_req();
        @(posedge adc_done);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
        idle(30);
        chk(n_bytes == b0, "R10 stop with done no byte", n_bytes, b0);
        chk(n_starts == s0 + 2, "R10 launches", n_starts, s0 + 2);
        expect_pair("R10 restart");
        pulse_rd();
        pulse_req();
        wait_bytes(b0 + 1);
        idle(1);
        pulse_ack(1'b1);
        pulse_req();
        wait_bytes(b0 + 2);
        idle(1);
        pulse_ack(1'b0);
        pulse_stop();
        idle(5);
        chk(n_bytes == b0 + 2, "R10 restart bytes", n_bytes, b0 + 2);

        // R11 stop after first byte
        s0 = n_starts;
        b0 = n_bytes;
        begin
            logic [11:0] v;
            v = sample_val(pred_idx);
            pred_idx++;
            exp_q.push_back(v[11:4]);
            tag_q.push_back("R11 hi byte");
        end
        pulse_rd();
        pulse_req();
        wait_bytes(b0 + 1);
        idle(1);
        pulse_stop();
        pulse_req();
        idle(30);
        chk(n_bytes == b0 + 1, "R11 no second byte", n_bytes, b0 + 1);
        chk(n_starts == s0 + 1, "R11 no launch", n_starts, s0 + 1);

        // R12 launch waits for busy low
        pulse_addr(8'(CH_BASE + 3));
        s0 = n_starts;
        b0 = n_bytes;
        expect_pair("R12 first");
        pulse_rd();
        pulse_req();
        wait_bytes(b0 + 1);
        idle(1);
        pulse_ack(1'b1);
        pulse_req();
        wait_bytes(b0 + 2);
        idle(1);
        ext_busy = 1'b1;
        expect_pair("R12 second");
        pulse_ack(1'b1);
        idle(10);
        chk(n_starts == s0 + 1, "R12 held while busy", n_starts, s0 + 1);
        ext_busy = 1'b0;
        wait_starts(s0 + 2);
        idle(1);
        chk(last_chan == 3, "R12 channel after release", last_chan, 3);
        pulse_req();
        wait_bytes(b0 + 3);
        idle(1);
        pulse_ack(1'b1);
        pulse_req();
        wait_bytes(b0 + 4);
        idle(1);
        pulse_ack(1'b0);
        pulse_stop();
        idle(10);

        chk(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);
        finish_run();
    end

endmodule